// File: doc/BRIEF.md
# Two-Level Page Walker

This block turns a 12-bit byte-addressed virtual address into a physical address by walking page tables held in physical memory. The virtual space is split in two by its top bit: addresses with that bit clear belong to user space, those with it set belong to system space. The system page table sits in physical memory at a base address supplied on `sbr`. The user page table, by contrast, lives in system virtual space at the base supplied on `ubr`, so the address of a user page-table entry must itself be translated through the system table before it can be read.

A requester presents an address, an access type and both base values with a one-cycle `start` pulse. The walker then issues single-word reads to memory, which answers with fixed one-cycle latency, checks the valid and access-control bits of every entry it fetches, and marks the final entry as modified on a permitted write. It ends with a one-cycle `done` pulse carrying either a physical address or a fault code. The data access itself is left to the requester.

Top module: `vat_walker`

## Requirements
- R1: After a synchronous reset `busy`, `done`, `mem_req` and `mem_we` are 0, `fault` is 0 and `pa` is 0.
- R2: When VA bit 11 is 1 the walker makes one entry read at physical address `sbr + VA[10:5]*2` and translates with that entry alone.
- R3: When VA bit 11 is 0 the entry virtual address is `T = ubr + VA[10:5]*2`; the walker reads the system entry at `sbr + T[10:5]*2`, then the user entry at `{system PFN, T[4:0]}`, and the result is `pa = {user PFN, VA[4:0]}`.
- R4: An entry is 16 bits: bit 15 valid, bit 14 modified, bits 13:12 access control, bit 11 unused, bits 10:0 the PFN.
- R5: An entry with bit 15 clear at either level ends the walk with `fault = 01` (page fault), `pa = 0` and no further memory access.
- R6: Access control on the final entry: 10 allows read and write, 01 allows read only, 00 and 11 allow nothing; a denied access ends with `fault = 10` and `pa = 0`. The system entry fetched for a user table is checked only for validity.
- R7: A permitted write adds one memory write to the final entry's address with the entry's value and bit 14 set; a read or a denied write writes nothing.
- R8: `done` rises on the 2nd rising edge after the edge that accepts `start` for a system read or any level-one page fault, the 3rd for a system write, the 4th for a user read, the 5th for a user write.
- R9: `done` is high for exactly one cycle, `fault` and `pa` hold their values until the next walk, and `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | 12 | Virtual address |
| wr | input | 1 | 1 = write access, 0 = read |
| ubr | input | 12 | User table base, a system-space virtual address |
| sbr | input | 16 | System table base, a physical address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| pa | output | 16 | Translated physical address, 0 on fault |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Physical address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
Translations are tried from both regions, with user pages whose table entries fall in different system pages, so a wrong index at either level lands on a different frame. Each access-control code is met with both a read and a write, which separates read-only from read-write and the two forbidden codes. Invalid entries are placed at the first level and at the second level to show the walk stops where it should, and the memory image is read back afterwards to see that only permitted writes marked their own entry. Directed runs measure the latency of each path and present a second start while busy.

// File: rtl/vat_pkg.sv
package vat_pkg;

    typedef enum logic [1:0] {
        F_NONE = 2'b00,
        F_PAGE = 2'b01,
        F_PROT = 2'b10
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1,
        S_L1W,
        S_L2,
        S_L2W,
        S_MOD
    } walk_state_e;

    // Permission check on the access-control field of a final entry.
    function automatic fault_e perm_check(input logic [1:0] ac, input logic is_wr);
        case (ac)
            2'b10:   return F_NONE;
            2'b01:   return is_wr ? F_PROT : F_NONE;
            default: return F_PROT;
        endcase
    endfunction

endpackage

// File: rtl/vat_addr_gen.sv
module vat_addr_gen #(
    parameter int VA_W       = 12,
    parameter int PA_W       = 16,
    parameter int PAGE_BYTES = 32,
    parameter int PTE_BYTES  = 2
) (
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] ubr,
    input  logic [PA_W-1:0] sbr,
    output logic [VA_W-1:0] l1_va,
    output logic [PA_W-1:0] l1_pa
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PTE_SH = $clog2(PTE_BYTES);
    localparam int RVPN_W = VA_W - 1 - OFF_W;

    logic [RVPN_W-1:0] uvpn;
    logic [RVPN_W-1:0] svpn;
    logic [VA_W-1:0]   ptva;

    always_comb begin
        uvpn  = va[VA_W-2:OFF_W];
        ptva  = ubr + (VA_W'(uvpn) << PTE_SH);
        l1_va = va[VA_W-1] ? va : ptva;
        svpn  = l1_va[VA_W-2:OFF_W];
        l1_pa = sbr + (PA_W'(svpn) << PTE_SH);
    end
endmodule

// File: rtl/vat_pte_check.sv
module vat_pte_check
    import vat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PFN_W  = 11
) (
    input  logic [WORD_W-1:0] pte,
    input  logic              is_wr,
    input  logic              final_lvl,
    output fault_e            flt,
    output logic [PFN_W-1:0]  pfn
);
    localparam int V_BIT  = WORD_W - 1;
    localparam int AC_HI  = WORD_W - 3;
    localparam int AC_LO  = WORD_W - 4;

    always_comb begin
        pfn = pte[PFN_W-1:0];
        if (!pte[V_BIT])
            flt = F_PAGE;
        else if (final_lvl)
            flt = perm_check(pte[AC_HI:AC_LO], is_wr);
        else
            flt = F_NONE;
    end
endmodule

// File: rtl/vat_walker.sv
module vat_walker
    import vat_pkg::*;
#(
    parameter int VA_W       = 12,
    parameter int PA_W       = 16,
    parameter int PAGE_BYTES = 32,
    parameter int PTE_BYTES  = 2,
    parameter int WORD_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VA_W-1:0]   va,
    input  logic              wr,
    input  logic [VA_W-1:0]   ubr,
    input  logic [PA_W-1:0]   sbr,
    output logic              busy,
    output logic              done,
    output logic [1:0]        fault,
    output logic [PA_W-1:0]   pa,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PFN_W = PA_W - OFF_W;
    localparam int M_BIT = WORD_W - 2;

    walk_state_e       state;
    logic [VA_W-1:0]   va_q, ubr_q;
    logic [PA_W-1:0]   sbr_q, l2_pa_q, pte_pa_q, pa_q;
    logic [WORD_W-1:0] pte_q;
    logic              wr_q, done_q;
    fault_e            fault_q;

    logic [VA_W-1:0]   l1_va;
    logic [PA_W-1:0]   l1_pa;
    fault_e            chk_flt;
    logic [PFN_W-1:0]  chk_pfn;
    logic              is_sys, final_lvl;

    assign is_sys    = va_q[VA_W-1];
    assign final_lvl = (state == S_L2W) || (state == S_L1W && is_sys);

    vat_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES), .PTE_BYTES(PTE_BYTES)
    ) u_addr (
        .va(va_q), .ubr(ubr_q), .sbr(sbr_q), .l1_va(l1_va), .l1_pa(l1_pa)
    );

    vat_pte_check #(.WORD_W(WORD_W), .PFN_W(PFN_W)) u_chk (
        .pte(mem_rdata), .is_wr(wr_q), .final_lvl(final_lvl),
        .flt(chk_flt), .pfn(chk_pfn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            va_q     <= '0;
            ubr_q    <= '0;
            sbr_q    <= '0;
            wr_q     <= 1'b0;
            l2_pa_q  <= '0;
            pte_pa_q <= '0;
            pte_q    <= '0;
            pa_q     <= '0;
            done_q   <= 1'b0;
            fault_q  <= F_NONE;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    va_q  <= va;
                    ubr_q <= ubr;
                    sbr_q <= sbr;
                    wr_q  <= wr;
                    state <= S_L1;
                end
                S_L1, S_L2: state <= (state == S_L1) ? S_L1W : S_L2W;
                S_L1W, S_L2W: begin
                    if (chk_flt != F_NONE) begin
                        fault_q <= chk_flt;
                        pa_q    <= '0;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end else if (final_lvl) begin
                        pa_q     <= {chk_pfn, va_q[OFF_W-1:0]};
                        pte_q    <= mem_rdata;
                        pte_pa_q <= (state == S_L1W) ? l1_pa : l2_pa_q;
                        fault_q  <= F_NONE;
                        if (wr_q) begin
                            state <= S_MOD;
                        end else begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end
                    end else begin
                        l2_pa_q <= {chk_pfn, l1_va[OFF_W-1:0]};
                        state   <= S_L2;
                    end
                end
                S_MOD: begin
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state == S_L1) || (state == S_L2) || (state == S_MOD);
        mem_we    = (state == S_MOD);
        mem_wdata = pte_q | (WORD_W'(1) << M_BIT);
        case (state)
            S_L2:    mem_addr = l2_pa_q;
            S_MOD:   mem_addr = pte_pa_q;
            default: mem_addr = l1_pa;
        endcase
    end

    assign busy  = (state != S_IDLE);
    assign done  = done_q;
    assign fault = fault_q;
    assign pa    = pa_q;

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
    a_r9_req_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    a_r5_fault_zero_pa: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'b00) |-> (pa == '0));
    a_r7_write_marks: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && wr_q && mem_wdata[M_BIT]));
    a_r7_write_last: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (done && fault == 2'b00));
endmodule

// File: tb/test_vat_walker.sv
module test_vat_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [11:0] va;
    logic        wr;
    logic [11:0] ubr;
    logic [15:0] sbr;
    logic        busy, done, mem_req, mem_we;
    logic [1:0]  fault;
    logic [15:0] pa, mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vat_walker i_vat_walker (
        .clk(clk), .rst(rst), .start(start), .va(va), .wr(wr), .ubr(ubr), .sbr(sbr),
        .busy(busy), .done(done), .fault(fault), .pa(pa),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [15:0] mem [256];
    int          nwrites = 0;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[8:1]] <= mem_wdata;
                nwrites <= nwrites + 1;
            end else begin
                mem_rdata <= mem[mem_addr[8:1]];
            end
        end
    end

    function automatic logic [15:0] pte(input logic v, input logic [1:0] ac, input int pfn);
        return {v, 1'b0, ac, 1'b0, 11'(pfn)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    int lat;
    task automatic walk(input logic [11:0] a, input logic w);
        int cyc;
        @(negedge clk);
        va = a; wr = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 walk hung actual %0d expected done", cyc);
        end
        lat = cyc - 1;
    endtask

    // {va, wr, fault, pa}
    localparam logic [30:0] VEC [15] = '{
        {12'h013, 1'b0, 2'b00, 16'h00F3},   // R3 user rw page, read
        {12'h013, 1'b1, 2'b00, 16'h00F3},   // R7 user write allowed
        {12'h025, 1'b0, 2'b00, 16'h0105},   // R6 read-only read
        {12'h025, 1'b1, 2'b10, 16'h0000},   // R6 read-only write
        {12'h04A, 1'b0, 2'b01, 16'h0000},   // R5 invalid user entry
        {12'h061, 1'b0, 2'b10, 16'h0000},   // R6 code 00
        {12'h22E, 1'b0, 2'b00, 16'h016E},   // R3 second system page
        {12'h400, 1'b0, 2'b01, 16'h0000},   // R5 invalid system entry
        {12'h640, 1'b0, 2'b10, 16'h0000},   // R6 code 11
        {12'h907, 1'b0, 2'b00, 16'h0127},   // R2 system read
        {12'h907, 1'b1, 2'b10, 16'h0000},   // R6 system read-only write
        {12'h93F, 1'b1, 2'b00, 16'h015F},   // R2 system write
        {12'h941, 1'b0, 2'b01, 16'h0000},   // R5 system invalid
        {12'h960, 1'b0, 2'b10, 16'h0000},   // R6 system code 00
        {12'h980, 1'b1, 2'b10, 16'h0000}    // R6 system code 11
    };

    initial begin
        #(20 * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        // system entries at 0x40 + 2*svpn (R4 layout)
        mem[8'h20] = pte(1, 2'b10, 4);
        mem[8'h21] = pte(1, 2'b10, 5);
        mem[8'h22] = pte(0, 2'b10, 3);
        mem[8'h23] = pte(1, 2'b01, 6);
        mem[8'h28] = pte(1, 2'b01, 9);
        mem[8'h29] = pte(1, 2'b10, 10);
        mem[8'h2A] = pte(0, 2'b10, 12);
        mem[8'h2B] = pte(1, 2'b00, 13);
        mem[8'h2C] = pte(1, 2'b11, 14);
        // user entries
        mem[8'h40] = pte(1, 2'b10, 7);
        mem[8'h41] = pte(1, 2'b01, 8);
        mem[8'h42] = pte(0, 2'b10, 2);
        mem[8'h43] = pte(1, 2'b00, 3);
        mem[8'h51] = pte(1, 2'b10, 11);
        mem[8'h62] = pte(1, 2'b11, 1);

        rst = 1'b1; start = 1'b0; va = '0; wr = 1'b0;
        ubr = 12'h800; sbr = 16'h0040;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 fault", 32'(fault), 0);
        check("R1 pa", 32'(pa), 0);
        check("R1 mem_req", 32'(mem_req), 0);

        for (int i = 0; i < 15; i++) begin
            walk(VEC[i][30:19], VEC[i][18]);
            check("R5/R6 fault", 32'(fault), 32'(VEC[i][17:16]));
            check("R2/R3 pa", 32'(pa), 32'(VEC[i][15:0]));
        end

        // R7: modify bits in the memory image
        check("R7 user entry marked", 32'(mem[8'h40]), 32'(pte(1, 2'b10, 7) | 16'h4000));
        check("R7 system entry marked", 32'(mem[8'h29]), 32'(pte(1, 2'b10, 10) | 16'h4000));
        check("R7 denied user unmarked", 32'(mem[8'h41]), 32'(pte(1, 2'b01, 8)));
        check("R7 denied system unmarked", 32'(mem[8'h28]), 32'(pte(1, 2'b01, 9)));
        check("R7 table page entry unmarked", 32'(mem[8'h20]), 32'(pte(1, 2'b10, 4)));
        check("R7 write count", 32'(nwrites), 2);

        // R8 latencies
        walk(12'h907, 1'b0); check("R8 system read", 32'(lat), 2);
        walk(12'h93F, 1'b1); check("R8 system write", 32'(lat), 3);
        walk(12'h013, 1'b0); check("R8 user read", 32'(lat), 4);
        walk(12'h013, 1'b1); check("R8 user write", 32'(lat), 5);
        walk(12'h400, 1'b0); check("R8 level-one fault", 32'(lat), 2);

        // R9 pulse width and hold
        walk(12'h22E, 1'b0);
        @(negedge clk);
        check("R9 done one cycle", 32'(done), 0);
        repeat (4) @(negedge clk);
        check("R9 pa held", 32'(pa), 32'h016E);
        check("R9 fault held", 32'(fault), 0);

        // R9 start ignored while busy
        @(negedge clk);
        va = 12'h013; wr = 1'b0; start = 1'b1;
        @(negedge clk);
        va = 12'h907; wr = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R9 first walk result", 32'(pa), 32'h00F3);
        begin
            int extra = 0;
            repeat (8) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R9 no second walk", 32'(extra), 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule